// File: doc/BRIEF.md
# Blind Maze Game Controller

This block runs a single-player maze game on a square grid. It keeps the player's cell coordinates and the game phase. The phases are an idle menu, a short preview in which the maze is shown, a blind phase in which the maze is hidden, and two end phases for a loss and a win. Directional buttons that have already been debounced move the player one cell per press. Before a move is committed, the destination cell is looked up in an external one-bit-per-cell map memory through a synchronous read port.

The length of the preview is chosen by a difficulty input and counted in pulses of a once-per-second enable. A move onto an obstacle cell ends the game as a loss. Arriving at the goal cell, thirty columns to the right of the start on the same row, ends it as a win. The centre button brings the game back to the menu from any phase. The display logic uses the coordinates, the maze-visible flag and a two-bit status colour code.

Top module: `maze_game_ctrl`

## Requirements
- R1: After reset, or in the cycle after the centre button is sampled high in any phase, the phase is menu: status code 2'b01 (blue), position (0, START_ROW) with START_ROW defaulting to 16, and maze hidden.
- R2: In the menu, only a rising edge of the up button starts the game. Other directions leave the position unchanged and the status blue.
- R3: The difficulty is sampled at start. Code 0 gives a preview of 4 ticks, code 1 gives 2 ticks, and codes 2 and 3 give 1 tick. The maze is visible with status 2'b00 during the preview and is hidden from the last preview tick onward.
- R4: Each rising edge of one direction button moves the player one cell: up is y-1, down is y+1, left is x-1, right is x+1. A held button moves the player only once.
- R5: A move that would leave the 32x32 grid is ignored.
- R6: A rising edge on more than one direction button in the same cycle is ignored.
- R7: The map read address is {y, x} of the destination cell, so the address is y*32+x. The memory's data is used one cycle after the address. A 1 bit means an obstacle: the player is placed on that cell and the phase becomes lost, with status 2'b10 (red) and the maze shown.
- R8: Arriving at (30, START_ROW) on a clear cell enters the won phase, with status 2'b11 (green) and the maze shown.
- R9: In the lost and won phases, direction buttons have no effect. The centre button returns the game to the menu.
- R10: Moves are accepted in both the preview phase and the blind phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| btnUp | input | 1 | Debounced up button |
| btnDown | input | 1 | Debounced down button |
| btnLeft | input | 1 | Debounced left button |
| btnRight | input | 1 | Debounced right button |
| btnCenter | input | 1 | Centre button; returns the game to the menu |
| difficulty | input | 2 | Preview length select |
| secTick | input | 1 | One-cycle pulse once per second |
| mapAddr | output | 10 | Map memory read address {y, x} |
| mapData | input | 1 | Obstacle bit, valid one cycle after the address |
| playerX | output | 5 | Player column |
| playerY | output | 5 | Player row |
| mazeVisible | output | 1 | Maze layout may be drawn |
| statusColor | output | 2 | 00 play, 01 menu, 10 lost, 11 won |

## Verification
Assertions check the following every cycle:
- The centre button always leads to the menu.
- The lost and won phases can only be left for the menu.
- The menu can only be left for the preview.
- The preview counter stays nonzero while the preview lasts.
- Every committed move changes exactly one coordinate.

Only the directed scenarios can show the rest:
- The preview length for each difficulty code.
- The direction of each button.
- Ignored moves at the grid edges and for simultaneous presses.
- That the map lookup uses the destination cell.
- The ends of the game on an obstacle and on the goal cell.

// File: rtl/maze_pkg.sv
package maze_pkg;

  typedef enum logic [2:0] {
    PH_MENU, PH_PREVIEW, PH_BLIND, PH_LOST, PH_WON
  } phase_t;

  // direction codes double as indices into the direction button vectors
  typedef enum logic [1:0] {
    DIR_UP = 2'd0, DIR_DOWN = 2'd1, DIR_LEFT = 2'd2, DIR_RIGHT = 2'd3
  } dir_t;

  typedef struct packed {
    logic loadStart;
    logic latchTarget;
    logic commitMove;
    dir_t dir;
  } dp_strobe_t;

  localparam logic [1:0] COLOR_PLAY = 2'b00;
  localparam logic [1:0] COLOR_MENU = 2'b01;
  localparam logic [1:0] COLOR_LOST = 2'b10;
  localparam logic [1:0] COLOR_WON  = 2'b11;

endpackage

// File: rtl/maze_datapath.sv
module maze_datapath
  import maze_pkg::*;
#(
  parameter int COORD_W   = 5,
  parameter int START_ROW = 16,
  parameter int GOAL_COL  = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           strb,
  output logic [COORD_W-1:0]   posX,
  output logic [COORD_W-1:0]   posY,
  output logic [3:0]           canMove,
  output logic                 tgtIsGoal,
  output logic [2*COORD_W-1:0] mapAddr
);

  localparam logic [COORD_W-1:0] MAX_C   = {COORD_W{1'b1}};
  localparam logic [COORD_W-1:0] START_Y = COORD_W'(START_ROW);
  localparam logic [COORD_W-1:0] GOAL_X  = COORD_W'(GOAL_COL);

  logic [COORD_W-1:0] tgtX, tgtY;

  always_ff @(posedge clk) begin
    if (!rstN || strb.loadStart) begin
      posX <= '0;
      posY <= START_Y;
      tgtX <= '0;
      tgtY <= START_Y;
    end else begin
      if (strb.latchTarget) begin
        case (strb.dir)
          DIR_UP:    tgtY <= posY - 1'b1;
          DIR_DOWN:  tgtY <= posY + 1'b1;
          DIR_LEFT:  tgtX <= posX - 1'b1;
          default:   tgtX <= posX + 1'b1;
        endcase
      end
      if (strb.commitMove) begin
        posX <= tgtX;
        posY <= tgtY;
      end
    end
  end

  always_comb begin
    canMove[DIR_UP]    = posY != '0;
    canMove[DIR_DOWN]  = posY != MAX_C;
    canMove[DIR_LEFT]  = posX != '0;
    canMove[DIR_RIGHT] = posX != MAX_C;
  end

  assign tgtIsGoal = (tgtX == GOAL_X) && (tgtY == START_Y);
  assign mapAddr   = {tgtY, tgtX};

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitMove && !strb.loadStart) |=>
      (((posX == $past(posX)) != (posY == $past(posY)))))
    else $error("committed move did not change exactly one coordinate");

endmodule

// File: rtl/maze_control.sv
module maze_control
  import maze_pkg::*;
#(
  parameter int PREVIEW_EASY = 4,
  parameter int PREVIEW_MID  = 2,
  parameter int PREVIEW_HARD = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnUp,
  input  logic       btnDown,
  input  logic       btnLeft,
  input  logic       btnRight,
  input  logic       btnCenter,
  input  logic [1:0] difficulty,
  input  logic       secTick,
  input  logic [3:0] canMove,
  input  logic       tgtIsGoal,
  input  logic       mapData,
  output dp_strobe_t strb,
  output logic       mazeVisible,
  output logic [1:0] statusColor
);

  localparam int CNT_W = $clog2(PREVIEW_EASY + 1);

  typedef enum logic [1:0] {CK_IDLE, CK_ADDR, CK_DATA} check_t;

  phase_t             phase;
  check_t             chkStage;
  logic [CNT_W-1:0]   previewCnt;
  logic [3:0]         dirNow, dirPrev, rise;
  dir_t               dirSel;
  logic               playing, moveOk;

  assign dirNow  = {btnRight, btnLeft, btnDown, btnUp};
  assign rise    = dirNow & ~dirPrev;
  assign playing = (phase == PH_PREVIEW) || (phase == PH_BLIND);

  always_comb begin
    case (rise)
      4'b0010: dirSel = DIR_DOWN;
      4'b0100: dirSel = DIR_LEFT;
      4'b1000: dirSel = DIR_RIGHT;
      default: dirSel = DIR_UP;
    endcase
  end

  assign moveOk = playing && (chkStage == CK_IDLE) && $onehot(rise) && canMove[dirSel];

  always_comb begin
    strb.loadStart   = btnCenter;
    strb.latchTarget = !btnCenter && moveOk;
    strb.commitMove  = !btnCenter && (chkStage == CK_DATA);
    strb.dir         = dirSel;
  end

  function automatic logic [CNT_W-1:0] previewLoad(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(PREVIEW_EASY);
      2'd1:    return CNT_W'(PREVIEW_MID);
      default: return CNT_W'(PREVIEW_HARD);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_MENU;
      chkStage   <= CK_IDLE;
      previewCnt <= '0;
      dirPrev    <= '0;
    end else begin
      dirPrev <= dirNow;
      if (btnCenter) begin
        phase      <= PH_MENU;
        chkStage   <= CK_IDLE;
        previewCnt <= '0;
      end else begin
        case (phase)
          PH_MENU: if (rise == 4'b0001) begin
            phase      <= PH_PREVIEW;
            previewCnt <= previewLoad(difficulty);
          end
          PH_PREVIEW, PH_BLIND: begin
            if (phase == PH_PREVIEW && secTick) begin
              if (previewCnt == CNT_W'(1)) phase <= PH_BLIND;
              previewCnt <= previewCnt - 1'b1;
            end
            case (chkStage)
              CK_IDLE: if (moveOk) chkStage <= CK_ADDR;
              CK_ADDR: chkStage <= CK_DATA;
              default: begin
                chkStage <= CK_IDLE;
                if (mapData)        phase <= PH_LOST;
                else if (tgtIsGoal) phase <= PH_WON;
              end
            endcase
          end
          default: chkStage <= CK_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (phase)
      PH_MENU: statusColor = COLOR_MENU;
      PH_LOST: statusColor = COLOR_LOST;
      PH_WON:  statusColor = COLOR_WON;
      default: statusColor = COLOR_PLAY;
    endcase
  end

  assign mazeVisible = (phase == PH_PREVIEW) || (phase == PH_LOST) || (phase == PH_WON);

  // R1
  centre_to_menu_chk: assert property (@(posedge clk) disable iff (!rstN)
    btnCenter |=> (statusColor == COLOR_MENU) && !mazeVisible)
    else $error("centre press did not reach the menu");

  // R9
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LOST) |=> (phase == PH_LOST) || (phase == PH_MENU))
    else $error("lost phase left other than to menu");

  // R9
  won_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WON) |=> (phase == PH_WON) || (phase == PH_MENU))
    else $error("won phase left other than to menu");

  // R2
  menu_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_MENU) |=> (phase == PH_MENU) || (phase == PH_PREVIEW))
    else $error("menu left other than to preview");

  // R3
  preview_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PREVIEW) |-> (previewCnt != '0) && (previewCnt <= CNT_W'(PREVIEW_EASY)))
    else $error("preview counter out of range");

endmodule

// File: rtl/maze_game_ctrl.sv
module maze_game_ctrl
  import maze_pkg::*;
#(
  parameter int COORD_W      = 5,
  parameter int START_ROW    = 16,
  parameter int GOAL_COL     = 30,
  parameter int PREVIEW_EASY = 4,
  parameter int PREVIEW_MID  = 2,
  parameter int PREVIEW_HARD = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 btnUp,
  input  logic                 btnDown,
  input  logic                 btnLeft,
  input  logic                 btnRight,
  input  logic                 btnCenter,
  input  logic [1:0]           difficulty,
  input  logic                 secTick,
  output logic [2*COORD_W-1:0] mapAddr,
  input  logic                 mapData,
  output logic [COORD_W-1:0]   playerX,
  output logic [COORD_W-1:0]   playerY,
  output logic                 mazeVisible,
  output logic [1:0]           statusColor
);

  dp_strobe_t strb;
  logic [3:0] canMove;
  logic       tgtIsGoal;

  maze_control #(
    .PREVIEW_EASY(PREVIEW_EASY), .PREVIEW_MID(PREVIEW_MID), .PREVIEW_HARD(PREVIEW_HARD)
  ) control_i (
    .clk(clk), .rstN(rstN),
    .btnUp(btnUp), .btnDown(btnDown), .btnLeft(btnLeft), .btnRight(btnRight),
    .btnCenter(btnCenter), .difficulty(difficulty), .secTick(secTick),
    .canMove(canMove), .tgtIsGoal(tgtIsGoal), .mapData(mapData),
    .strb(strb), .mazeVisible(mazeVisible), .statusColor(statusColor)
  );

  maze_datapath #(
    .COORD_W(COORD_W), .START_ROW(START_ROW), .GOAL_COL(GOAL_COL)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .posX(playerX), .posY(playerY), .canMove(canMove),
    .tgtIsGoal(tgtIsGoal), .mapAddr(mapAddr)
  );

endmodule

// File: tb/maze_game_ctrl_tb_top.sv
module maze_game_ctrl_tb_top;

  localparam logic [3:0] M_UP = 4'b0001, M_DOWN = 4'b0010, M_LEFT = 4'b0100, M_RIGHT = 4'b1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] dirs = '0;
  logic       btnCenter = 1'b0;
  logic [1:0] difficulty = '0;
  logic       secTick = 1'b0;
  logic [9:0] mapAddr;
  logic       mapData;
  logic [4:0] playerX, playerY;
  logic       mazeVisible;
  logic [1:0] statusColor;
  logic       mapMem [1024];
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) mapData <= mapMem[mapAddr];

  maze_game_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .btnUp(dirs[0]), .btnDown(dirs[1]), .btnLeft(dirs[2]), .btnRight(dirs[3]),
    .btnCenter(btnCenter), .difficulty(difficulty), .secTick(secTick),
    .mapAddr(mapAddr), .mapData(mapData),
    .playerX(playerX), .playerY(playerY),
    .mazeVisible(mazeVisible), .statusColor(statusColor)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkState(input string req, input int x, input int y, input int col, input int vis);
    chk({req, " x"}, playerX, x);
    chk({req, " y"}, playerY, y);
    chk({req, " status"}, statusColor, col);
    chk({req, " visible"}, mazeVisible, vis);
  endtask

  task automatic press(input logic [3:0] m);
    @(negedge clk) dirs = m;
    @(negedge clk) dirs = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic centre();
    @(negedge clk) btnCenter = 1'b1;
    @(negedge clk) btnCenter = 1'b0;
    @(negedge clk);
  endtask

  task automatic startGame(input logic [1:0] d);
    difficulty = d;
    press(M_UP);
  endtask

  task automatic testReset();
    chkState("R1 reset", 0, 16, 1, 0);
  endtask

  task automatic testMenu();
    press(M_RIGHT);
    press(M_DOWN);
    chkState("R2 menu ignores moves", 0, 16, 1, 0);
  endtask

  task automatic testPlay();
    startGame(2'd1);
    chkState("R3 preview entered", 0, 16, 0, 1);
    tick();
    chk("R3 mid preview visible", mazeVisible, 1);
    press(M_RIGHT);
    chk("R10 move in preview", playerX, 1);
    tick();
    chk("R3 hidden after 2 ticks", mazeVisible, 0);
    chk("R3 blind status", statusColor, 0);
    press(M_RIGHT);
    chk("R10 move in blind", playerX, 2);
    @(negedge clk) dirs = M_LEFT;
    repeat (8) @(negedge clk);
    dirs = '0;
    repeat (4) @(negedge clk);
    chk("R4 held left moves once", playerX, 1);
    press(M_DOWN);
    chk("R4 down", playerY, 17);
    press(M_UP);
    chk("R4 up", playerY, 16);
    press(M_UP | M_RIGHT);
    chkState("R6 simultaneous ignored", 1, 16, 0, 0);
    press(M_LEFT);
    press(M_LEFT);
    chk("R5 left edge", playerX, 0);
    centre();
    chkState("R1 centre from blind", 0, 16, 1, 0);
  endtask

  task automatic testTopEdge();
    startGame(2'd3);
    tick();
    chk("R3 hard one tick", mazeVisible, 0);
    for (int i = 0; i < 16; i++) press(M_UP);
    chk("R4 reach top row", playerY, 0);
    press(M_UP);
    chkState("R5 top edge", 0, 0, 0, 0);
    centre();
  endtask

  task automatic testLost();
    startGame(2'd0);
    for (int i = 0; i < 3; i++) tick();
    chk("R3 easy visible after 3", mazeVisible, 1);
    tick();
    chk("R3 easy hidden after 4", mazeVisible, 0);
    press(M_UP);
    chk("R4 up clear", playerY, 15);
    press(M_RIGHT);
    chkState("R7 obstacle lost", 1, 15, 2, 1);
    chk("R7 map address", mapAddr, 15 * 32 + 1);
    press(M_DOWN);
    chkState("R9 lost ignores moves", 1, 15, 2, 1);
    centre();
    chkState("R9 centre from lost", 0, 16, 1, 0);
  endtask

  task automatic testWon();
    startGame(2'd2);
    tick();
    for (int i = 0; i < 29; i++) press(M_RIGHT);
    chkState("R8 before goal", 29, 16, 0, 0);
    press(M_RIGHT);
    chkState("R8 goal won", 30, 16, 3, 1);
    press(M_RIGHT);
    chk("R9 won ignores moves", playerX, 30);
    centre();
    chkState("R9 centre from won", 0, 16, 1, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mapMem[i] = 1'b0;
    mapMem[15 * 32 + 1] = 1'b1;
    mapMem[17 * 32 + 5] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMenu();
    testPlay();
    testTopEdge();
    testLost();
    testWon();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule